// File: doc/BRIEF.md
# ECC Word Memory Write Controller with Read-Modify-Write

This block joins a byte-addressed processor port to a memory that stores only whole 32-bit words. Each word is kept with seven SECDED check bits. The processor may read or write 8, 16 or 32 bits at any byte address. The memory sees only word addresses, and every write carries the full data word together with freshly computed check bits.

A 32-bit write to an aligned address goes straight to memory as one write. Any other write becomes a read of the word, an ECC check, a byte merge and a write-back of the whole word. An access that runs past the end of a word is split into two word operations: the lower word first, then the next one. Single-bit errors are corrected wherever a word is read. A word with an uncorrectable error is never written. The processor request then completes with an error flag.

The request side uses valid/ready. The processor raises `req_valid` with its command and must keep every request field steady until it sees `req_ready` high at a clock edge. `req_ready` is high for exactly one cycle, when the last memory cycle of the sequence has finished. `rsp_rdata` and `rsp_err` are valid only in that cycle, and there is no back-pressure on the response. The memory port has no handshake: an enabled read returns its word on `mem_rdata` in the following cycle.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: A write with `req_size` selecting 32 bits and `req_addr[1:0]`==0 performs exactly one memory write and no memory read.
- R2: Every other write handles each word it touches as a read of that word, followed in the next cycle by a write to the same word address. The write-back keeps every byte outside the request unchanged.
- R3: An access whose bytes run past the end of a word uses two words: word `addr>>2` first, then the next word, wrapping to word 0 after the last one. Byte order is little-endian: request byte k lives at byte address addr+k, and byte address 4w+j is bits [8j+7:8j] of word w.
- R4: A 32-bit write at byte offset 2 of word w produces exactly four memory cycles in this order: read w, write w, read w+1, write w+1.
- R5: The stored word is 39 bits, with data in [31:0] and check bits in [38:32], and an all-zero word is a valid codeword. A flip of any single one of the 39 bits is corrected on a read, and the read completes without error.
- R6: A single-bit error found while reading a word for a merge is corrected before the merge. The word written back carries no error.
- R7: A word read with two flipped bits makes the request complete with `rsp_err`=1. That word is not written, and no later word of the request is accessed. Words written earlier in the same request keep their new value.
- R8: After reset and while no request is pending, `req_ready` and `mem_en` are low. `req_ready` is high for one cycle per request, only while `req_valid` is high.
- R9: `req_size` encodes 0 as 8 bits, 1 as 16 bits, and 2 or 3 as 32 bits. Read data is zero-extended above the requested width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Request complete (one-cycle pulse) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access width code (R9) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_err | output | 1 | Uncorrectable error, valid with req_ready |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 39 | Check bits and data to store |
| mem_rdata | input | 39 | Stored word, one cycle after a read |

## Verification
The bench sweeps every byte address for every width. It checks the exact sequence of memory operations and the read-back data against a byte-level shadow. A controller that merged at the wrong lane, forgot to wrap, or read before an aligned full write would corrupt neighbouring bytes or show the wrong operation count.

Each of the 39 stored bit positions is flipped in turn, both before plain reads and before merges. A decoder with a wrong syndrome map would return bad data. Skipping the correction in the merge would leave a first error in memory, and the bench exposes it by adding a second flip and reading again.

Double-bit faults are placed in the only word, in the first word and in the second word of a crossing write. A controller that wrote back after a fault, or carried on to the next word, would change stored words or issue extra memory cycles.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WFULL,
    ST_RD,
    ST_CHK,
    ST_DONE
  } ctl_state_e;

  // Hamming position (non power of two, starting at 3) of data bit d
  function automatic logic [HAM_W-1:0] bit_slot(input int d);
    int n;
    logic [HAM_W-1:0] r;
    n = 0;
    r = '0;
    for (int p = 1; p <= DATA_W + HAM_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == d) r = HAM_W'(p);
        n++;
      end
    end
    return r;
  endfunction

  // Hamming parity bits over the data word
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    logic [HAM_W-1:0] s;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      s = bit_slot(i);
      for (int j = 0; j < HAM_W; j++) begin
        if (s[j]) h[j] = h[j] ^ d[i];
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/ecc_rmw_enc.sv
module ecc_rmw_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  logic [HAM_W-1:0] ham;

  assign ham   = ham_bits(data);
  // top bit makes the parity of the whole 39-bit word even
  assign check = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec
  import ecc_rmw_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data_ok,
  output logic              unc
);
  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  chk;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              hit;

  assign raw = code[DATA_W-1:0];
  assign chk = code[CODE_W-1:DATA_W];
  assign syn = ham_bits(raw) ^ chk[HAM_W-1:0];
  assign odd = ^code;

  always_comb begin
    data_ok = raw;
    unc     = 1'b0;
    hit     = 1'b0;
    if (odd) begin
      // odd parity: one flip; only a data-bit syndrome needs repair
      if ((syn & (syn - 1'b1)) != '0) begin
        for (int i = 0; i < DATA_W; i++) begin
          if (bit_slot(i) == syn) begin
            data_ok[i] = ~raw[i];
            hit        = 1'b1;
          end
        end
        if (!hit) unc = 1'b1;
      end
    end else if (syn != '0) begin
      unc = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_rmw_lanes.sv
module ecc_rmw_lanes
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic              phase,
  input  logic [1:0]        off,
  input  logic [2:0]        nbytes,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] acc_out
);
  logic [LANES-1:0] sel;
  logic [1:0]       idx [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [3:0] lin;
    logic [3:0] k;
    // linear byte position of this lane within the two-word window
    assign lin    = {1'b0, phase, 2'(j)};
    assign k      = lin - {2'b00, off};
    assign sel[j] = (lin >= {2'b00, off}) && (k < {1'b0, nbytes});
    assign idx[j] = k[1:0];
    assign new_word[8*j +: 8] = sel[j] ? wdata[8*idx[j] +: 8] : old_word[8*j +: 8];
  end

  always_comb begin
    acc_out = acc_in;
    for (int j = 0; j < LANES; j++) begin
      if (sel[j]) acc_out[8*idx[j] +: 8] = old_word[8*j +: 8];
    end
  end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [CODE_W-1:0]   mem_wdata,
  input  logic [CODE_W-1:0]   mem_rdata
);
  localparam int WA_W = ADDR_W - 2;

  ctl_state_e        st_q, st_d;
  logic              wr_q, ph_q, two_q, err_q;
  logic [2:0]        nb_q;
  logic [1:0]        off_q;
  logic [DATA_W-1:0] wd_q, acc_q;
  logic [WA_W-1:0]   word_q;

  logic [2:0]        req_nb;
  logic              req_full;
  logic [DATA_W-1:0] fix_data, merged, acc_nxt, enc_in;
  logic [CHK_W-1:0]  enc_chk;
  logic              unc;

  always_comb begin
    case (req_size)
      2'd0:    req_nb = 3'd1;
      2'd1:    req_nb = 3'd2;
      default: req_nb = 3'd4;
    endcase
  end

  assign req_full = req_write && (req_nb == 3'd4) && (req_addr[1:0] == 2'b00);

  ecc_rmw_dec dec_i (
    .code    (mem_rdata),
    .data_ok (fix_data),
    .unc     (unc)
  );

  ecc_rmw_lanes lanes_i (
    .old_word (fix_data),
    .phase    (ph_q),
    .off      (off_q),
    .nbytes   (nb_q),
    .wdata    (wd_q),
    .acc_in   (acc_q),
    .new_word (merged),
    .acc_out  (acc_nxt)
  );

  // one encoder shared by the direct write and the merge write-back
  assign enc_in = (st_q == ST_WFULL) ? wd_q : merged;

  ecc_rmw_enc enc_i (
    .data  (enc_in),
    .check (enc_chk)
  );

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    st_d   = st_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) st_d = req_full ? ST_WFULL : ST_RD;
      end
      ST_WFULL: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        st_d   = ST_DONE;
      end
      ST_RD: begin
        mem_en = 1'b1;
        st_d   = ST_CHK;
      end
      ST_CHK: begin
        if (unc) begin
          st_d = ST_DONE;
        end else begin
          if (wr_q) begin
            mem_en = 1'b1;
            mem_we = 1'b1;
          end
          st_d = (two_q && !ph_q) ? ST_RD : ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign mem_addr  = word_q;
  assign mem_wdata = {enc_chk, enc_in};
  assign req_ready = (st_q == ST_DONE);
  assign rsp_rdata = acc_q;
  assign rsp_err   = (st_q == ST_DONE) && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      ph_q   <= 1'b0;
      two_q  <= 1'b0;
      err_q  <= 1'b0;
      nb_q   <= 3'd0;
      off_q  <= 2'd0;
      wd_q   <= '0;
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid) begin
        wr_q   <= req_write;
        nb_q   <= req_nb;
        off_q  <= req_addr[1:0];
        wd_q   <= req_wdata;
        word_q <= req_addr[ADDR_W-1:2];
        ph_q   <= 1'b0;
        two_q  <= ({1'b0, req_addr[1:0]} + req_nb) > 3'd4;
        acc_q  <= '0;
        err_q  <= 1'b0;
      end else if (st_q == ST_CHK) begin
        if (unc) begin
          err_q <= 1'b1;
        end else begin
          acc_q <= acc_nxt;
          if (two_q && !ph_q) begin
            ph_q   <= 1'b1;
            word_q <= word_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ecc_rmw_chk.sv
module ecc_rmw_chk
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr
);
  p_full_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 2'd2 && req_addr[1:0] == 2'b00 && mem_en) |-> mem_we);

  p_rmw_same_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr)));

  p_cross_next_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rsp_err) |-> !$past(mem_en && mem_we));

  p_ready_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_idle_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_en);

  p_zext_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_write && req_size == 2'd0) |-> (rsp_rdata[31:8] == 24'd0));

  p_zext_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_write && req_size == 2'd1) |-> (rsp_rdata[31:16] == 16'd0));
endmodule

bind ecc_rmw_ctrl ecc_rmw_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/ecc_rmw_ctrl_tb_top.sv
module ecc_rmw_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int WA_W   = ADDR_W - 2;
  localparam int NW     = 1 << WA_W;
  localparam int NB     = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_ready, req_write;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata, rsp_rdata;
  logic              rsp_err;
  logic              mem_en, mem_we;
  logic [WA_W-1:0]   mem_addr;
  logic [38:0]       mem_wdata, mem_rdata;

  ecc_rmw_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model with one-cycle read, fault injection and an operation log
  logic [38:0]     mem [NW];
  logic            inj_en;
  logic [WA_W-1:0] inj_addr;
  logic [38:0]     inj_mask;
  int              op_total;
  logic            log_we [8];
  logic [WA_W-1:0] log_addr [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
      op_total <= 0;
    end else begin
      if (mem_en) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else        mem_rdata     <= mem[mem_addr];
        log_we[op_total % 8]   <= mem_we;
        log_addr[op_total % 8] <= mem_addr;
        op_total <= op_total + 1;
      end
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    end
  end

  int total = 0;
  int bad = 0;
  logic [7:0]  shadow [NB];
  logic [31:0] got_rdata;
  logic        got_err;
  int          ops_start, n_ops;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes_of(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_rd(input int sz, input int a);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < nbytes_of(sz); k++) r[8*k +: 8] = shadow[(a + k) % NB];
    return r;
  endfunction

  function automatic void shadow_wr(input int sz, input int a, input logic [31:0] wd, input int upto);
    for (int k = 0; k < nbytes_of(sz) && k < upto; k++) shadow[(a + k) % NB] = wd[8*k +: 8];
  endfunction

  function automatic logic [31:0] pat(input int n);
    return (32'(n) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic do_req(input logic wr, input int sz, input int a, input logic [31:0] wd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 2'(sz);
    req_addr  = ADDR_W'(a);
    req_wdata = wd;
    ops_start = op_total;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_ready && guard < 50);
    check(req_ready == 1'b1, "R8 completion", 64'(req_ready), 64'd1);
    got_rdata = rsp_rdata;
    got_err   = rsp_err;
    @(negedge clk);
    req_valid = 1'b0;
    n_ops = op_total - ops_start;
    check(req_ready == 1'b0 && mem_en == 1'b0, "R8 single ready pulse",
          64'({req_ready, mem_en}), 64'd0);
  endtask

  task automatic inject(input int w, input logic [38:0] m);
    @(negedge clk);
    inj_en   = 1'b1;
    inj_addr = WA_W'(w);
    inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic full_wr(input int w, input logic [31:0] v);
    do_req(1'b1, 2, 4 * w, v);
    shadow_wr(2, 4 * w, v, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [38:0] snap;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
    for (int i = 0; i < NB; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R8 reset ready", 64'(req_ready), 64'd0);
    check(mem_en == 1'b0, "R8 reset mem idle", 64'(mem_en), 64'd0);
    rst_n = 1'b1;

    // sweep of every width at every byte address
    for (int sz = 0; sz < 3; sz++) begin
      for (int a = 0; a < NB; a++) begin
        int nb, off, nw;
        bit full;
        logic [31:0] wd;
        nb = nbytes_of(sz);
        off = a % 4;
        nw = (off + nb > 4) ? 2 : 1;
        full = (sz == 2 && off == 0);
        wd = pat(a * 3 + sz + 1);
        do_req(1'b1, sz, a, wd);
        check(got_err == 1'b0, "R2 clean write error flag", 64'(got_err), 64'd0);
        if (full) check(n_ops == 1, "R1 aligned word write op count", 64'(n_ops), 64'd1);
        else      check(n_ops == 2 * nw, "R2 read-merge-write op count", 64'(n_ops), 64'(2 * nw));
        if (n_ops <= 4) begin
          for (int i = 0; i < n_ops; i++) begin
            int ix;
            logic ew;
            logic [WA_W-1:0] ea;
            ix = (ops_start + i) % 8;
            ew = full ? 1'b1 : 1'(i % 2);
            ea = WA_W'(a / 4 + i / 2);
            check(log_we[ix] == ew && log_addr[ix] == ea,
                  (sz == 2 && off == 2) ? "R4 four-cycle order" : "R3 word order",
                  64'({log_we[ix], log_addr[ix]}), 64'({ew, ea}));
          end
        end
        shadow_wr(sz, a, wd, 4);
        do_req(1'b0, sz, a, 32'd0);
        check(got_rdata == exp_rd(sz, a),
              (sz < 2) ? "R9 zero-extended readback" : "R3 little-endian readback",
              64'(got_rdata), 64'(exp_rd(sz, a)));
        check(n_ops == nw, "R3 read word count", 64'(n_ops), 64'(nw));
      end
    end

    // single-bit errors on reads, every stored bit
    for (int b = 0; b < 39; b++) begin
      int w;
      w = (b % 2 == 0) ? 5 : 6;
      full_wr(w, pat(100 + b));
      inject(w, 39'd1 << b);
      if (b % 2 == 0) begin
        do_req(1'b0, 2, 20, 32'd0);
        check(got_rdata == exp_rd(2, 20) && !got_err, "R5 corrected aligned read",
              64'({got_err, got_rdata}), 64'({1'b0, exp_rd(2, 20)}));
      end else begin
        do_req(1'b0, 2, 22, 32'd0);
        check(got_rdata == exp_rd(2, 22) && !got_err, "R5 corrected crossing read",
              64'({got_err, got_rdata}), 64'({1'b0, exp_rd(2, 22)}));
      end
      full_wr(w, pat(100 + b));
    end

    // single-bit errors during merge, every stored bit
    for (int b = 0; b < 39; b++) begin
      full_wr(5, pat(200 + b));
      inject(5, 39'd1 << b);
      do_req(1'b1, 0, 21, pat(300 + b));
      check(got_err == 1'b0, "R6 merge with corrected error", 64'(got_err), 64'd0);
      shadow_wr(0, 21, pat(300 + b), 4);
      inject(5, 39'd1 << ((b + 7) % 39));
      do_req(1'b0, 2, 20, 32'd0);
      check(got_rdata == exp_rd(2, 20) && !got_err, "R6 write-back was clean",
            64'({got_err, got_rdata}), 64'({1'b0, exp_rd(2, 20)}));
      full_wr(5, pat(200 + b));
    end

    // double-bit errors: the faulting word is never written
    for (int b = 0; b < 39; b += 3) begin
      logic [38:0] m;
      m = (39'd1 << b) | (39'd1 << ((b + 11) % 39));
      full_wr(5, pat(400 + b));
      inject(5, m);
      snap = mem[5];
      do_req(1'b1, 1, 21, pat(500 + b));
      check(got_err == 1'b1, "R7 partial write faults", 64'(got_err), 64'd1);
      check(n_ops == 1, "R7 no write-back after fault", 64'(n_ops), 64'd1);
      check(mem[5] == snap, "R7 faulting word unchanged", 64'(mem[5]), 64'(snap));
      do_req(1'b0, 2, 20, 32'd0);
      check(got_err == 1'b1, "R7 read reports fault", 64'(got_err), 64'd1);
      full_wr(5, pat(400 + b));
    end

    // crossing write with fault in the second word
    full_wr(5, 32'h11223344);
    full_wr(6, 32'h55667788);
    inject(6, 39'h3);
    snap = mem[6];
    do_req(1'b1, 2, 22, 32'hA1B2C3D4);
    check(got_err == 1'b1, "R7 second word fault", 64'(got_err), 64'd1);
    check(n_ops == 3, "R7 stop after second read", 64'(n_ops), 64'd3);
    check(mem[6] == snap, "R7 second word unchanged", 64'(mem[6]), 64'(snap));
    shadow_wr(2, 22, 32'hA1B2C3D4, 2);
    do_req(1'b0, 2, 20, 32'd0);
    check(got_rdata == exp_rd(2, 20) && !got_err, "R7 first word kept new bytes",
          64'({got_err, got_rdata}), 64'({1'b0, exp_rd(2, 20)}));
    full_wr(6, 32'h55667788);

    // crossing write with fault in the first word
    inject(5, 39'h5 << 30);
    snap = mem[6];
    do_req(1'b1, 2, 23, 32'hCAFEF00D);
    check(got_err == 1'b1, "R7 first word fault", 64'(got_err), 64'd1);
    check(n_ops == 1, "R7 next word not accessed", 64'(n_ops), 64'd1);
    check(mem[6] == snap, "R7 next word unchanged", 64'(mem[6]), 64'(snap));
    full_wr(5, 32'h11223344);

    // final read sweep against the shadow
    for (int sz = 0; sz < 3; sz++) begin
      for (int a = 0; a < NB; a++) begin
        do_req(1'b0, sz, a, 32'd0);
        check(got_rdata == exp_rd(sz, a) && !got_err, "R3 final read sweep",
              64'({got_err, got_rdata}), 64'({1'b0, exp_rd(sz, a)}));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule